// File: doc/BRIEF.md
# Command-Word MDIO Management Master

This block is a management-interface master that reaches external Ethernet PHYs over the two-wire MDC/MDIO bus. Software controls it through a single 32-bit word, and that word is used both to issue a command and to collect its result. A write with the top bit set launches exactly one management frame. The frame's start code, opcode, port address, register or device address and payload are all taken from fields of that same word. The master sends the frame serially. On a read it gives up the data line at the turnaround and shifts the PHY's 16 reply bits back into the low half of the word. When the frame ends, the top bit drops.

Both Clause 22 and Clause 45 framing are supported. The 2-bit start-type field goes out on the wire unchanged as the start code. The 2-bit command field goes out unchanged as the opcode, and its meaning depends on the clause. A Clause 45 access is two separate commands: an address frame followed by a data frame. Software issues the second only after the first has cleared busy. The port is a plain control/status register: there is no stream handshake. A write that arrives while busy is dropped, so software must poll bit 31 before it writes again.

MDC comes from a divider whose half period is `CLK_HZ / (2*MDC_HZ)` system cycles. MDC is held low whenever no frame is running.

Top module: `mdio_cmd_master`

## Requirements
- R1: While `rst` is high at a clock edge, the block returns to idle. `cmd_rdata` reads 0x4000_0000 (busy 0, ready 1, every field and the captured data cleared), `mdc` is low and `mdio_oe` is low.
- R2: A write while idle stores bits 29:0. If bit 31 of the written word is 1, a frame starts: bit 31 reads 1 and bit 30 (ready) reads 0 from the next cycle. If bit 31 is 0, nothing is sent and `mdc` stays low.
- R3: A write while bit 31 reads 1 is dropped. The stored fields, the captured data and the frame on the wire are left as they were.
- R4: Each frame is 64 MDC cycles, sent most significant bit first. The order is: 32 ones, the start code equal to bits 17:16, the opcode equal to bits 19:18, the port address bits 24:20, then the register/device address bits 29:25, then 2 turnaround bits and 16 data bits.
- R5: Every frame that is not a read drives the turnaround as 1 then 0, followed by bits 15:0 (write data, or the Clause 45 register address). `mdio_oe` stays high for all 64 bits.
- R6: A read is start type 1 with command 2 (Clause 22), or start type 0 with command 2 or 3 (Clause 45 post-read-increment and read). On a read, `mdio_oe` is low from bit 46 to bit 63, and `mdio_i` is sampled at the MDC rising edge of bits 48 to 63. At completion those 16 bits replace bits 15:0.
- R7: Each MDC half period lasts `CLK_HZ/(2*MDC_HZ)` cycles. `mdio_o` changes only while MDC is low, never at its rising edge. Busy clears exactly 128 half periods after the launching edge, and MDC is low and `mdio_oe` is low whenever busy is 0.
- R8: A command write in the very cycle a frame completes is dropped: busy reads 0 afterwards, the fields are unchanged and no new frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_we | input | 1 | Write strobe for the command word |
| cmd_wdata | input | 32 | Command word being written |
| cmd_rdata | output | 32 | Busy, ready, stored fields and data/result |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_i | input | 1 | Sampled level of the MDIO line |
| mdio_o | output | 1 | Value driven onto MDIO when enabled |
| mdio_oe | output | 1 | MDIO output enable, high while the master drives |

## Verification
Two functions can coincide in one cycle: the sequencer finishing the last bit and clearing busy, and software writing a fresh command. The bench counts cycles from the launching edge and drives a new launch word into exactly the cycle whose closing edge ends the frame. It then requires busy low, the old fields intact and MDC quiet afterwards. A mid-frame write is provoked the same way, and the resulting frame and word are compared with values the bench predicts from the original command.

// File: rtl/mdio_cmd_pkg.sv
package mdio_cmd_pkg;

  localparam int FRAME_BITS = 64;
  localparam int TA_BIT     = 46;
  localparam int DATA_BIT   = 48;

  localparam logic [1:0] ST_C45 = 2'd0;
  localparam logic [1:0] ST_C22 = 2'd1;

  // Field order matches bits 29:16 of the command word
  typedef struct packed {
    logic [4:0] regdev;
    logic [4:0] phy;
    logic [1:0] op;
    logic [1:0] st;
  } mdio_hdr_t;

  function automatic logic hdr_is_read(mdio_hdr_t h);
    return (h.st == ST_C22 && h.op == 2'b10) || (h.st == ST_C45 && h.op[1]);
  endfunction

  function automatic logic [FRAME_BITS-1:0] build_frame(mdio_hdr_t h, logic [15:0] d);
    logic [1:0] ta;
    ta = hdr_is_read(h) ? 2'b11 : 2'b10;
    return {32'hFFFF_FFFF, h.st, h.op, h.phy, h.regdev, ta, d};
  endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int HALF = 40
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic mdc,
  output logic rise_stb,
  output logic fall_stb
);

  logic mdc_q;
  assign mdc = mdc_q;

  generate
    if (HALF <= 1) begin : g_fast
      // toggle every cycle, no counter needed
      always_ff @(posedge clk) begin
        if (rst || !run) mdc_q <= 1'b0;
        else             mdc_q <= ~mdc_q;
      end
      assign rise_stb = run && !mdc_q;
      assign fall_stb = run && mdc_q;
    end else begin : g_cnt
      localparam int CW = $clog2(HALF);
      localparam logic [CW-1:0] LAST = CW'(HALF - 1);
      logic [CW-1:0] cnt_q;
      logic          wrap;
      assign wrap = run && (cnt_q == LAST);
      always_ff @(posedge clk) begin
        if (rst || !run) begin
          cnt_q <= '0;
          mdc_q <= 1'b0;
        end else if (wrap) begin
          cnt_q <= '0;
          mdc_q <= ~mdc_q;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
      assign rise_stb = wrap && !mdc_q;
      assign fall_stb = wrap && mdc_q;
    end
  endgenerate

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_cmd_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [FRAME_BITS-1:0] frame_in,
  input  logic                  is_rd_in,
  input  logic                  rise_stb,
  input  logic                  fall_stb,
  input  logic                  mdio_i,
  output logic                  active,
  output logic                  mdio_o,
  output logic                  mdio_oe,
  output logic                  done,
  output logic [15:0]           cap_data
);

  localparam int IW = $clog2(FRAME_BITS);
  localparam logic [IW-1:0] LAST_IDX = IW'(FRAME_BITS - 1);

  logic [FRAME_BITS-1:0] shreg_q;
  logic [IW-1:0]         idx_q;
  logic                  act_q;
  logic                  rd_q;
  logic [15:0]           cap_q;

  assign active   = act_q;
  assign mdio_o   = shreg_q[FRAME_BITS-1];
  assign mdio_oe  = act_q && !(rd_q && idx_q >= IW'(TA_BIT));
  assign done     = act_q && fall_stb && (idx_q == LAST_IDX);
  assign cap_data = cap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg_q <= '0;
      idx_q   <= '0;
      act_q   <= 1'b0;
      rd_q    <= 1'b0;
      cap_q   <= '0;
    end else if (!act_q) begin
      if (start) begin
        shreg_q <= frame_in;
        idx_q   <= '0;
        act_q   <= 1'b1;
        rd_q    <= is_rd_in;
      end
    end else begin
      if (rise_stb && rd_q && idx_q >= IW'(DATA_BIT))
        cap_q <= {cap_q[14:0], mdio_i};
      if (fall_stb) begin
        shreg_q <= {shreg_q[FRAME_BITS-2:0], 1'b1};
        idx_q   <= idx_q + 1'b1;
        if (idx_q == LAST_IDX) act_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/mdio_cmd_master.sv
module mdio_cmd_master
  import mdio_cmd_pkg::*;
#(
  parameter int CLK_HZ = 200_000_000,
  parameter int MDC_HZ = 2_500_000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cmd_we,
  input  logic [31:0] cmd_wdata,
  output logic [31:0] cmd_rdata,
  output logic        mdc,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe
);

  localparam int RATIO    = CLK_HZ / (2 * MDC_HZ);
  localparam int HALF_CYC = (RATIO < 1) ? 1 : RATIO;

  mdio_hdr_t   hdr_q;
  mdio_hdr_t   hdr_in;
  logic [15:0] data_q;
  logic        busy_q;
  logic        rd_q;
  logic        launch;
  logic        seq_active;
  logic        seq_done;
  logic        rise_stb;
  logic        fall_stb;
  logic [15:0] cap;
  logic        unused_ready_wr;

  assign unused_ready_wr = cmd_wdata[30];
  assign hdr_in    = mdio_hdr_t'(cmd_wdata[29:16]);
  assign launch    = cmd_we && !busy_q && cmd_wdata[31];
  assign cmd_rdata = {busy_q, !busy_q, hdr_q, data_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      hdr_q  <= '0;
      data_q <= '0;
    end else if (busy_q) begin
      // writes are dropped while a frame runs, including the final cycle
      if (seq_done) begin
        busy_q <= 1'b0;
        if (rd_q) data_q <= cap;
      end
    end else if (cmd_we) begin
      hdr_q  <= hdr_in;
      data_q <= cmd_wdata[15:0];
      busy_q <= cmd_wdata[31];
      rd_q   <= hdr_is_read(hdr_in);
    end
  end

  mdio_mdc_gen #(.HALF(HALF_CYC)) u_mdc (
    .clk      (clk),
    .rst      (rst),
    .run      (seq_active),
    .mdc      (mdc),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb)
  );

  mdio_frame_seq u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (launch),
    .frame_in (build_frame(hdr_in, cmd_wdata[15:0])),
    .is_rd_in (hdr_is_read(hdr_in)),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb),
    .mdio_i   (mdio_i),
    .active   (seq_active),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .done     (seq_done),
    .cap_data (cap)
  );

endmodule

// File: rtl/mdio_cmd_master_chk.sv
module mdio_cmd_master_chk (
  input logic        clk,
  input logic        rst,
  input logic        cmd_we,
  input logic [31:0] cmd_wdata,
  input logic [31:0] cmd_rdata,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe
);

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (cmd_rdata == 32'h4000_0000 && !mdc && !mdio_oe)); // R1

  AST_LAUNCH_BUSY: assert property (@(posedge clk) disable iff (rst)
    (cmd_we && cmd_wdata[31] && !cmd_rdata[31]) |=> (cmd_rdata[31] && !cmd_rdata[30])); // R2

  AST_FIELDS_HELD: assert property (@(posedge clk) disable iff (rst)
    cmd_rdata[31] |=> $stable(cmd_rdata[29:16])); // R3

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !cmd_rdata[31] |-> (!mdc && !mdio_oe)); // R7

  AST_HOLD_AT_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(mdc) |-> $stable(mdio_o)); // R7

endmodule

bind mdio_cmd_master mdio_cmd_master_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_we    (cmd_we),
  .cmd_wdata (cmd_wdata),
  .cmd_rdata (cmd_rdata),
  .mdc       (mdc),
  .mdio_o    (mdio_o),
  .mdio_oe   (mdio_oe)
);

// File: tb/mdio_cmd_master_bench.sv
`timescale 1ns/1ps
module mdio_cmd_master_bench;

  localparam int CLK_HZ    = 200_000_000;
  localparam int MDC_HZ    = 25_000_000;
  localparam int HALF      = CLK_HZ / (2 * MDC_HZ);
  localparam int FRAME_CYC = 128 * HALF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_we = 1'b0;
  logic [31:0] cmd_wdata = '0;
  wire  [31:0] cmd_rdata;
  wire         mdc, mdio_o, mdio_oe;
  logic        phy_drv = 1'b0, phy_bit = 1'b0, phy_en = 1'b0;
  logic [15:0] phy_data = '0;
  wire         mdio_line = mdio_oe ? mdio_o : (phy_drv ? phy_bit : 1'b1);

  int tests = 0, fails = 0, rc = 0;
  logic [63:0] mon_bits = '0, mon_oe = '0;

  always #2.5 clk = ~clk;

  mdio_cmd_master #(.CLK_HZ(CLK_HZ), .MDC_HZ(MDC_HZ)) u_mdio_cmd_master (
    .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .cmd_rdata(cmd_rdata), .mdc(mdc), .mdio_i(mdio_line),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  // Line monitor and PHY responder
  always @(posedge mdc) begin
    #1;
    mon_bits = {mon_bits[62:0], mdio_line};
    mon_oe   = {mon_oe[62:0], mdio_oe};
    #1;
    if (phy_en && rc >= 46 && rc <= 62) begin
      phy_drv = 1'b1;
      phy_bit = (rc == 46) ? 1'b0 : phy_data[62 - rc];
    end else begin
      phy_drv = 1'b0;
    end
    rc++;
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit exp_is_read(logic [31:0] w);
    return (w[17:16] == 2'd1 && w[19:18] == 2'd2) || (w[17:16] == 2'd0 && w[19]);
  endfunction

  function automatic logic [31:0] mkw(logic [4:0] rg, logic [4:0] ph, logic [1:0] op,
                                     logic [1:0] st, logic [15:0] d);
    return {1'b1, 1'b0, rg, ph, op, st, d};
  endfunction

  function automatic logic [63:0] exp_frame(logic [31:0] w, bit en, logic [15:0] pd);
    if (exp_is_read(w))
      return {32'hFFFF_FFFF, w[17:16], w[19:18], w[24:20], w[29:25], 1'b1, !en, en ? pd : 16'hFFFF};
    return {32'hFFFF_FFFF, w[17:16], w[19:18], w[24:20], w[29:25], 2'b10, w[15:0]};
  endfunction

  // inj: 0 none, 1 write mid-frame, 2 write in completion cycle
  task automatic do_cmd(input logic [31:0] w, input bit en, input logic [15:0] pd, input int inj);
    bit rd = exp_is_read(w);
    logic [15:0] exp_d = rd ? (en ? pd : 16'hFFFF) : w[15:0];
    logic [63:0] exp_oe = rd ? {{46{1'b1}}, 18'h0} : {64{1'b1}};
    int n = 0;
    @(negedge clk);
    phy_en = en && rd; phy_data = pd; phy_drv = 1'b0; rc = 0;
    mon_bits = '0; mon_oe = '0;
    cmd_we = 1'b1; cmd_wdata = w;
    @(negedge clk);
    cmd_we = 1'b0;
    chk(cmd_rdata[31:30] == 2'b10, "R2 busy/ready after launch", 64'(cmd_rdata[31:30]), 64'd2);
    chk(cmd_rdata[29:16] == w[29:16], "R2 fields stored", 64'(cmd_rdata[29:16]), 64'(w[29:16]));
    while (cmd_rdata[31] && n < FRAME_CYC + 50) begin
      @(negedge clk);
      n++;
      if (cmd_we) begin
        cmd_we = 1'b0;
        if (inj == 1)
          chk(cmd_rdata[29:0] == w[29:0], "R3 write while busy dropped",
              64'(cmd_rdata[29:0]), 64'(w[29:0]));
      end
      if (inj == 1 && n == 100) begin
        cmd_we = 1'b1; cmd_wdata = ~w | 32'h8000_0000;
      end
      if (inj == 2 && n == FRAME_CYC - 1) begin
        cmd_we = 1'b1; cmd_wdata = (w ^ 32'h3FFF_0000) | 32'h8000_0000;
      end
    end
    cmd_we = 1'b0;
    chk(n == FRAME_CYC, "R7 frame duration", 64'(n), 64'(FRAME_CYC));
    chk(rc == 64, "R4 MDC rising edge count", 64'(rc), 64'd64);
    chk(mon_bits == exp_frame(w, en, pd), rd ? "R6 read frame on wire" : "R5 write frame on wire",
        mon_bits, exp_frame(w, en, pd));
    chk(mon_oe == exp_oe, rd ? "R6 release pattern" : "R5 drive pattern", mon_oe, exp_oe);
    chk(cmd_rdata == {2'b01, w[29:16], exp_d}, rd ? "R6 captured word" : "R5 final word",
        64'(cmd_rdata), 64'({2'b01, w[29:16], exp_d}));
    if (inj == 2) begin
      repeat (10) @(negedge clk);
      chk(!mdc && !cmd_rdata[31] && rc == 64 && cmd_rdata[29:16] == w[29:16],
          "R8 write at completion dropped", 64'(cmd_rdata), 64'({2'b01, w[29:16], exp_d}));
    end
    phy_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL R7 watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] w;
    void'($urandom(32'd20250611));
    repeat (5) @(negedge clk);
    chk(cmd_rdata == 32'h4000_0000 && !mdc && !mdio_oe, "R1 reset state",
        64'(cmd_rdata), 64'h4000_0000);
    rst = 1'b0;

    // Idle write without the launch bit
    @(negedge clk);
    cmd_we = 1'b1; cmd_wdata = 32'h2A5B_1234;
    @(negedge clk);
    cmd_we = 1'b0;
    chk(cmd_rdata == 32'h6A5B_1234, "R2 store without launch", 64'(cmd_rdata), 64'h6A5B_1234);
    repeat (20) @(negedge clk);
    chk(rc == 0 && !mdc && !cmd_rdata[31], "R2 no frame without launch bit", 64'(rc), 64'd0);

    // Directed Clause 22
    do_cmd(mkw(5'd3, 5'd1, 2'd1, 2'd1, 16'hBEEF), 1'b0, 16'h0, 0);
    do_cmd(mkw(5'd2, 5'd31, 2'd2, 2'd1, 16'h0), 1'b1, 16'h7500, 0);
    do_cmd(mkw(5'd2, 5'd0, 2'd2, 2'd1, 16'h0), 1'b0, 16'h0, 0);
    // Directed Clause 45: address, read, post-read-increment, write
    do_cmd(mkw(5'd1, 5'd5, 2'd0, 2'd0, 16'h0010), 1'b0, 16'h0, 0);
    do_cmd(mkw(5'd1, 5'd5, 2'd3, 2'd0, 16'h0), 1'b1, 16'h1234, 0);
    do_cmd(mkw(5'd1, 5'd5, 2'd2, 2'd0, 16'h0), 1'b1, 16'hCAFE, 0);
    do_cmd(mkw(5'd7, 5'd9, 2'd1, 2'd0, 16'h5A5A), 1'b0, 16'h0, 0);
    // Collisions
    do_cmd(mkw(5'd4, 5'd6, 2'd1, 2'd1, 16'h0F0F), 1'b0, 16'h0, 1);
    do_cmd(mkw(5'd8, 5'd2, 2'd2, 2'd1, 16'h0), 1'b1, 16'h8421, 2);

    // Random mix
    for (int i = 0; i < 10; i++) begin
      w = $urandom;
      w[31] = 1'b1;
      do_cmd(w, 1'($urandom % 2), 16'($urandom), 0);
    end

    // Reset after a captured read clears the data field
    do_cmd(mkw(5'd1, 5'd1, 2'd2, 2'd1, 16'h0), 1'b1, 16'hA5C3, 0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk(cmd_rdata == 32'h4000_0000, "R1 captured data cleared", 64'(cmd_rdata), 64'h4000_0000);

    // Reset in the middle of a frame
    @(negedge clk);
    rc = 0; cmd_we = 1'b1; cmd_wdata = mkw(5'd3, 5'd3, 2'd1, 2'd1, 16'hFFFF);
    @(negedge clk); cmd_we = 1'b0;
    repeat (50) @(negedge clk);
    rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk(cmd_rdata == 32'h4000_0000 && !mdc && !mdio_oe, "R1 reset mid-frame",
        64'(cmd_rdata), 64'h4000_0000);
    w = 32'(rc);
    repeat (20) @(negedge clk);
    chk(32'(rc) == w && !mdc, "R1 bus quiet after reset", 64'(rc), 64'(w));

    finish_run();
  end

endmodule